// File: doc/BRIEF.md
# Flash Access Violation Detector

This block sits beside the program-flash controller and judges every flash access as it is issued. Four kinds of access are watched: instruction fetches (including branch targets), data-space reads of code memory, program-store writes and erases. Each one is compared against a configurable lock-byte address. Any address strictly above that boundary lies outside user code space. The block also takes two status inputs: a security-deny signal from the protection logic and the enable state of the supply-voltage monitor.

When an access breaks a rule, the block raises a fault strobe for one clock and reports a cause code on the clock after the access. The reset controller uses the strobe to start a system reset and to record flash error as the reset cause. When several rules are broken in the same cycle, the code names the one with the highest priority. The flash array, the decoding of the security settings and the reset sequencing are outside this block.

Top module: `flash_guard`

## Requirements
- R1: While `rst_i` is high at a clock edge, `fault_o` is 0 and `cause_o` is 0 after that edge, whatever the access inputs are.
- R2: An access with `acc_valid_i` low never faults. A write (`acc_kind_i`=2) or erase (`acc_kind_i`=3) with `store_wen_i` low is not a flash access and never faults.
- R3: Any flash access with `sec_deny_i` high faults with cause 1. This covers fetches (kind 0), data reads (kind 1), and writes or erases with `store_wen_i` high.
- R4: A write or erase with `store_wen_i` high faults with cause 2 when `vmon_en_i` is low. Fetches and data reads do not depend on `vmon_en_i`.
- R5: A write or erase with `store_wen_i` high whose address is strictly greater than `lock_addr_i` faults with cause 3.
- R6: A data read of code memory (kind 1) whose address is strictly greater than `lock_addr_i` faults with cause 4.
- R7: An instruction fetch (kind 0) whose address is strictly greater than `lock_addr_i` faults with cause 5.
- R8: An address equal to or below `lock_addr_i` is legal for every access kind, unless R3 or R4 applies.
- R9: When several rules apply to one access, the cause is chosen in this order: security (1), then supply monitor (2), then write above lock (3), then read above lock (4), then fetch above lock (5).
- R10: The result of an access presented before a clock edge appears just after that edge and lasts exactly one clock. `fault_o` is high exactly when `cause_o` is non-zero. Back-to-back illegal accesses give one strobe per access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_kind_i | input | 2 | 0 fetch, 1 data read of code memory, 2 write, 3 erase |
| acc_addr_i | input | ADDR_W | Target address of the access |
| store_wen_i | input | 1 | Program-store write-enable control bit |
| lock_addr_i | input | ADDR_W | Lock-byte address, highest legal address |
| sec_deny_i | input | 1 | Security setting forbids this access |
| vmon_en_i | input | 1 | Supply-voltage monitor is enabled |
| fault_o | output | 1 | Registered one-cycle fault strobe |
| cause_o | output | 3 | Fault cause code, 0 when there is no fault |

## Verification
The assertions check on every cycle that an idle access stays silent and that the strobe agrees with a non-zero cause. They also check that a denied access always reports cause 1, that a write with the monitor off reports cause 2, and that an address at or below the lock boundary with no other violation never faults. The boundary itself (lock, lock+1, all-ones lock, zero lock), the full priority ladder when rules overlap, writes ignored while the enable bit is low, and reset arriving in the same cycle as a violation are shown only by the bench's scenarios. Those scenarios are compared against a scoreboard that models the requirements.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    localparam int CAUSE_W   = 3;
    localparam int NUM_RULES = 5;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_DREAD = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_ERASE = 2'd3
    } acc_kind_e;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_SECURE  = 3'd1,
        CAUSE_SUPPLY  = 3'd2,
        CAUSE_WR_HIGH = 3'd3,
        CAUSE_RD_HIGH = 3'd4,
        CAUSE_FX_HIGH = 3'd5
    } fault_cause_e;

    // Packed so that bit 0 is the highest-priority rule.
    typedef struct packed {
        logic fx_high;
        logic rd_high;
        logic wr_high;
        logic supply;
        logic secure;
    } rule_hits_t;

    function automatic logic is_modify(acc_kind_e k);
        return (k == KIND_WRITE) || (k == KIND_ERASE);
    endfunction

    function automatic logic [CAUSE_W-1:0] code_of_rule(int idx);
        return CAUSE_W'(idx + 1);
    endfunction

endpackage

// File: rtl/fg_screen.sv
module fg_screen
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              valid_i,
    input  acc_kind_e         kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wen_i,
    input  logic [ADDR_W-1:0] lock_i,
    input  logic              sec_deny_i,
    input  logic              vmon_en_i,
    output rule_hits_t        hits_o
);

    logic modify;
    logic live;
    logic above;

    always_comb begin
        modify = is_modify(kind_i);
        // A write or erase only reaches flash with the enable bit set.
        live   = valid_i && (!modify || wen_i);
        above  = addr_i > lock_i;

        hits_o.secure  = live && sec_deny_i;
        hits_o.supply  = live && modify && !vmon_en_i;
        hits_o.wr_high = live && modify && above;
        hits_o.rd_high = live && (kind_i == KIND_DREAD) && above;
        hits_o.fx_high = live && (kind_i == KIND_FETCH) && above;
    end

endmodule

// File: rtl/fg_prio.sv
module fg_prio
    import flash_guard_pkg::*;
#(
    parameter int NUM = NUM_RULES
) (
    input  logic [NUM-1:0] hits_i,
    output fault_cause_e   cause_o,
    output logic           any_o
);

    logic [NUM-1:0]     win;
    logic [CAUSE_W-1:0] code;

    // Rule g wins only when no lower-indexed (higher-priority) rule hits.
    for (genvar g = 0; g < NUM; g++) begin : g_win
        if (g == 0) begin : g_top
            assign win[g] = hits_i[0];
        end else begin : g_rest
            assign win[g] = hits_i[g] & ~(|hits_i[g-1:0]);
        end
    end

    always_comb begin
        code = '0;
        for (int i = 0; i < NUM; i++) begin
            if (win[i]) code = code | code_of_rule(i);
        end
    end

    assign cause_o = fault_cause_e'(code);
    assign any_o   = |hits_i;

endmodule

// File: rtl/fg_hold.sv
module fg_hold
    import flash_guard_pkg::*;
(
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         any_i,
    input  fault_cause_e cause_i,
    output logic         fault_o,
    output fault_cause_e cause_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fault_o <= 1'b0;
            cause_o <= CAUSE_NONE;
        end else begin
            fault_o <= any_i;
            cause_o <= any_i ? cause_i : CAUSE_NONE;
        end
    end

    // R1: a reset edge leaves the outputs quiet
    a_r1_reset_quiet: assert property (@(posedge clk_i)
        rst_i |=> (!fault_o && cause_o == CAUSE_NONE));

    // R10: a strobe always carries a cause
    a_r10_strobe_has_cause: assert property (@(posedge clk_i) disable iff (rst_i)
        fault_o |-> (cause_o != CAUSE_NONE));

    // R10: no strobe, no cause
    a_r10_idle_no_cause: assert property (@(posedge clk_i) disable iff (rst_i)
        !fault_o |-> (cause_o == CAUSE_NONE));

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              acc_valid_i,
    input  logic [1:0]        acc_kind_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic              store_wen_i,
    input  logic [ADDR_W-1:0] lock_addr_i,
    input  logic              sec_deny_i,
    input  logic              vmon_en_i,
    output logic              fault_o,
    output logic [2:0]        cause_o
);

    rule_hits_t   hits;
    fault_cause_e win_cause;
    logic         any_hit;
    fault_cause_e held_cause;

    fg_screen #(.ADDR_W(ADDR_W)) u_screen (
        .valid_i    (acc_valid_i),
        .kind_i     (acc_kind_e'(acc_kind_i)),
        .addr_i     (acc_addr_i),
        .wen_i      (store_wen_i),
        .lock_i     (lock_addr_i),
        .sec_deny_i (sec_deny_i),
        .vmon_en_i  (vmon_en_i),
        .hits_o     (hits)
    );

    fg_prio #(.NUM(NUM_RULES)) u_prio (
        .hits_i  (hits),
        .cause_o (win_cause),
        .any_o   (any_hit)
    );

    fg_hold u_hold (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .any_i   (any_hit),
        .cause_i (win_cause),
        .fault_o (fault_o),
        .cause_o (held_cause)
    );

    assign cause_o = held_cause;

    // R2: an idle cycle produces no strobe on the next
    a_r2_idle_silent: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(acc_valid_i)) |-> !fault_o);

    // R3: a denied flash access always reports the security cause
    a_r3_denied_faults: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(acc_valid_i && sec_deny_i
            && (!acc_kind_i[1] || store_wen_i)))
        |-> (fault_o && cause_o == 3'd1));

    // R4: an enabled write or erase with the monitor off reports cause 2
    a_r4_supply_off: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(acc_valid_i && !sec_deny_i && acc_kind_i[1]
            && store_wen_i && !vmon_en_i))
        |-> (fault_o && cause_o == 3'd2));

    // R8: at or below the lock boundary with nothing else wrong is legal
    a_r8_at_lock_legal: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(!sec_deny_i && vmon_en_i
            && acc_addr_i <= lock_addr_i))
        |-> !fault_o);

endmodule

// File: tb/flash_guard_test.sv
`timescale 1ns/1ps
module flash_guard_test;

    localparam int AW = 16;

    typedef struct {
        logic       fault;
        logic [2:0] cause;
        string      tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid = 1'b0;
    logic [1:0]    kind = 2'd0;
    logic [AW-1:0] addr = '0;
    logic          wen = 1'b0;
    logic [AW-1:0] lock = '0;
    logic          sec = 1'b0;
    logic          vmon = 1'b1;
    logic          fault;
    logic [2:0]    cause;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    flash_guard #(.ADDR_W(AW)) uut (
        .clk_i(clk), .rst_i(rst), .acc_valid_i(valid), .acc_kind_i(kind),
        .acc_addr_i(addr), .store_wen_i(wen), .lock_addr_i(lock),
        .sec_deny_i(sec), .vmon_en_i(vmon), .fault_o(fault), .cause_o(cause)
    );

    // Expected cause from the requirements (0 = legal).
    function automatic logic [2:0] expect_cause(logic v, logic [1:0] k,
            logic [AW-1:0] a, logic w, logic [AW-1:0] l, logic s, logic m);
        logic is_wr;
        is_wr = (k == 2'd2) || (k == 2'd3);
        if (!v) return 3'd0;              // R2
        if (is_wr && !w) return 3'd0;     // R2
        if (s) return 3'd1;               // R3
        if (is_wr && !m) return 3'd2;     // R4
        if (a > l) begin
            if (is_wr) return 3'd3;       // R5
            if (k == 2'd1) return 3'd4;   // R6
            return 3'd5;                  // R7
        end
        return 3'd0;                      // R8
    endfunction

    task automatic check(string tag, logic [2:0] got_c, logic got_f,
                         logic [2:0] exp_c, logic exp_f);
        n_cmp++;
        if (got_c !== exp_c || got_f !== exp_f) begin
            n_bad++;
            $display("FAIL %s: fault=%0b cause=%0d expected fault=%0b cause=%0d",
                     tag, got_f, got_c, exp_f, exp_c);
        end
    endtask

    // Driver: present one access and push its expected result.
    task automatic send(logic v, logic [1:0] k, logic [AW-1:0] a, logic w,
                        logic [AW-1:0] l, logic s, logic m, string tag);
        exp_t e;
        @(negedge clk);
        valid = v; kind = k; addr = a; wen = w; lock = l; sec = s; vmon = m;
        e.cause = expect_cause(v, k, a, w, l, s, m);
        e.fault = (e.cause != 3'd0);
        e.tag   = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare just after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, cause, fault, e.cause, e.fault);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    localparam logic [AW-1:0] LK = 16'h7FFF;

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R1 reset state", cause, fault, 3'd0, 1'b0);
        // R1: reset wins over an illegal access in the same cycle
        @(negedge clk);
        valid = 1'b1; kind = 2'd0; addr = 16'hFFFF; lock = LK; sec = 1'b1;
        @(posedge clk);
        #1 check("R1 reset beats violation", cause, fault, 3'd0, 1'b0);
        @(negedge clk);
        rst = 1'b0; valid = 1'b0; sec = 1'b0;

        send(0, 2'd0, 16'hFFFF, 1, LK, 1, 0, "R2 invalid with deny");
        send(1, 2'd2, 16'hFFFF, 0, LK, 1, 0, "R2 write without enable");
        send(1, 2'd3, 16'h9000, 0, LK, 0, 1, "R2 erase without enable");
        send(1, 2'd0, LK,       0, LK, 0, 1, "R8 fetch at lock");
        send(1, 2'd0, LK + 1,   0, LK, 0, 1, "R7 fetch lock+1");
        send(1, 2'd1, LK,       0, LK, 0, 1, "R8 read at lock");
        send(1, 2'd1, 16'hA000, 0, LK, 0, 1, "R6 read above");
        send(1, 2'd2, 16'h8000, 1, LK, 0, 1, "R5 write above");
        send(1, 2'd3, 16'hFFFF, 1, LK, 0, 1, "R5 erase above");
        send(1, 2'd3, LK,       1, LK, 0, 1, "R8 erase at lock");
        send(1, 2'd2, 16'h0100, 1, LK, 0, 0, "R4 write monitor off");
        send(1, 2'd1, 16'h0100, 0, LK, 0, 0, "R4 read ignores monitor");
        send(1, 2'd0, 16'h0100, 0, LK, 0, 0, "R4 fetch ignores monitor");
        send(1, 2'd1, 16'h0010, 0, LK, 1, 1, "R3 denied read below");
        send(1, 2'd0, 16'h0010, 0, LK, 1, 1, "R3 denied fetch");
        send(1, 2'd3, 16'h0010, 1, LK, 1, 1, "R3 denied erase");
        send(1, 2'd2, 16'hF000, 1, LK, 1, 0, "R9 security over supply");
        send(1, 2'd2, 16'hF000, 1, LK, 0, 0, "R9 supply over write-high");
        send(1, 2'd1, 16'hF000, 0, LK, 1, 0, "R9 security over read-high");
        send(0, 2'd0, 16'h0000, 0, LK, 0, 1, "R10 idle between");
        send(1, 2'd0, 16'hFFFF, 0, LK, 0, 1, "R10 back-to-back 1");
        send(1, 2'd1, 16'hFFFF, 0, LK, 0, 1, "R10 back-to-back 2");
        send(0, 2'd0, 16'hFFFF, 0, LK, 0, 1, "R10 strobe ends");
        send(1, 2'd0, 16'hFFFF, 0, 16'hFFFF, 0, 1, "R8 all-ones lock");
        send(1, 2'd1, 16'h0000, 0, 16'h0000, 0, 1, "R8 zero lock at zero");
        send(1, 2'd0, 16'h0001, 0, 16'h0000, 0, 1, "R7 zero lock plus one");
        // Sweep around several boundaries for every kind.
        for (int b = 0; b < 4; b++) begin
            for (int k = 0; k < 4; k++) begin
                for (int d = -1; d <= 1; d++) begin
                    logic [AW-1:0] lb;
                    lb = AW'(16'h1000 * (b + 1) + 16'h0123);
                    send(1, 2'(k), AW'(int'(lb) + d), 1, lb, 0, 1,
                         (k < 2) ? ((k == 0) ? "R7 sweep fetch" : "R6 sweep read")
                                 : "R5 sweep write/erase");
                end
            end
        end
        send(0, 2'd0, 16'h0000, 0, LK, 0, 1, "R2 final idle");
        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end

endmodule